// File: doc/BRIEF.md
# Multi-mode compare counter timer

This block is a compare-driven counter that turns a stream of count ticks into one of eight waveforms. A 3-bit function code picks the waveform. It can be a level change after a programmed count, a train of single-tick pulses, one pulse or a continuous rectangular wave of programmed delay and width, a waveform that alternates between two delay/width pairs, a bit pattern shifted out once or in a loop, or a free-running count that changes its output level exactly once. The tick arrives already selected and divided, as a one-system-clock strobe. Counting advances only on ticks where both the local enable and the global enable are high.

Four 16-bit compare words set the timing. Words 0 and 1 are the delay and terminal counts, and words 2 and 3 are the auxiliary pair for the alternating mode. Taken together, the four words form a 64-bit pattern store. A clear input holds the counter at zero and parks the engine. Writing a new function code restarts it in the same way. The waveform level passes through a polarity inversion to form the primary signal, and the secondary signal is its complement. Each of the two output pins has a 2-bit select that picks its own signal, the other signal, a forced low or a forced high. Each waveform event can raise a one-cycle interrupt strobe, which the interrupt enable gates.

Top module: `cmp_wave_timer`

## Requirements
- R1: After reset the waveform level is low, the interrupt strobe is low, and with both selects at 0 and polarity 0, out_pri is 0 and out_sec is 1.
- R2: The engine advances only on a system clock edge where tick, cfg_en and glb_en are all high. While cfg_clr is high, the counter is zero and the engine is back at its starting state (level low, alternate phase 0), whatever the enables are.
- R3: When cfg_mode differs from the value it had on the previous clock, the engine restarts at that edge in the same way as a clear.
- R4: Code 0: after D advancing ticks the level goes high and stays high, with one interrupt at that edge. D is compare word 0, with 0 read as 1.
- R5: Code 1: every D-th advancing tick sets the level high until the next advancing tick and raises an interrupt. D is compare word 0, with 0 read as 1.
- R6: Code 2: the level rises on the D-th advancing tick and falls on the T-th. At the T-th tick the counter returns to zero, one interrupt is raised and the engine stops. D is word 0 and T is word 1, each with 0 read as 1.
- R7: Code 3: the same waveform as code 2, but it repeats with period T and raises an interrupt at each wrap.
- R8: Code 7: the same waveform as code 3, but each wrap swaps the delay/terminal pair between words 0/1 and words 2/3, starting with words 0/1.
- R9: Code 4: a one-cycle trig while idle arms the engine. Then each advancing tick outputs bit k of the 64-bit vector {word3,word2,word1,word0} (bit 0 first) for k = 0..cfg_len. On the next advancing tick the level returns low, an interrupt is raised and the engine idles again.
- R10: Code 5: the same bit sequence as code 4, repeated without a trigger, with an interrupt on the tick that outputs bit cfg_len. A trig stops it and forces the level low.
- R11: Code 6: the counter runs freely and wraps at 2^16. The level rises once, when the count reaches word 0 (0 read as 1), with a single interrupt, and it stays high across wraps.
- R12: The primary signal is the level XOR cfg_pol and the secondary signal is its complement. The select codes are 0 = own signal, 1 = the other signal, 2 = forced low, 3 = forced high. cfg_osel drives out_pri and cfg_osel2 drives out_sec.
- R13: irq is high for exactly the clock after an edge that produced a waveform event, and only when cfg_ie was high at that edge. The level change and the strobe happen on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Function code |
| cfg_cmp | input | 4x16 | Compare words 0..3 (also the pattern store) |
| cfg_len | input | 6 | Index of the last pattern bit sent |
| cfg_pol | input | 1 | Inverts the primary signal |
| cfg_en | input | 1 | Local enable |
| cfg_clr | input | 1 | Holds the counter at zero and restarts the engine |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_osel | input | 2 | Select for out_pri |
| cfg_osel2 | input | 2 | Select for out_sec |
| glb_en | input | 1 | Global enable |
| tick | input | 1 | Count tick strobe |
| trig | input | 1 | Pattern start / stop strobe |
| out_pri | output | 1 | Primary output pin |
| out_sec | output | 1 | Secondary output pin |
| irq | output | 1 | Interrupt strobe |

## Verification
Every piece of engine state except the counter reaches the pins on the edge that changes it. A wrong counter value shows at the pins within one delay or terminal period, as an early or late edge on out_pri together with a misplaced irq strobe. A stuck alternate phase or a wrong pattern index shows as a wrong width or a wrong bit within one waveform cycle. A wrong one-shot or fired flag shows only when the engine should stop or refire, so the free-running check has to run past a full 2^16 wrap before such an error appears.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  localparam int FN_W  = 3;
  localparam int SEL_W = 2;

  typedef enum logic [FN_W-1:0] {
    FN_ONCE       = 3'd0,
    FN_REPEAT     = 3'd1,
    FN_PULSE_ONCE = 3'd2,
    FN_PULSE_REP  = 3'd3,
    FN_PAT_ONCE   = 3'd4,
    FN_PAT_REP    = 3'd5,
    FN_FREE       = 3'd6,
    FN_ALT        = 3'd7
  } fn_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_OWN   = 2'd0,
    SEL_OTHER = 2'd1,
    SEL_LOW   = 2'd2,
    SEL_HIGH  = 2'd3
  } osel_e;
endpackage

// File: rtl/cwt_ctl.sv
module cwt_ctl
  import cwt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FN_W-1:0] cfg_mode,
  input  logic            cfg_clr,
  input  logic            cfg_en,
  input  logic            glb_en,
  input  logic            tick,
  output logic            rst_sn,
  output logic            restart,
  output logic            step
);
  logic [1:0]      sync_q;
  logic [FN_W-1:0] mode_q;

  // reset released synchronously
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sn = sync_q[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) mode_q <= FN_ONCE;
    else         mode_q <= cfg_mode;
  end

  assign restart = cfg_clr | (cfg_mode != mode_q);
  assign step    = tick & cfg_en & glb_en;
endmodule

// File: rtl/cwt_outsel.sv
module cwt_outsel
  import cwt_pkg::*;
(
  input  logic             own_sig,
  input  logic             other_sig,
  input  logic [SEL_W-1:0] sel,
  output logic             pin
);
  always_comb begin
    unique case (osel_e'(sel))
      SEL_OWN:   pin = own_sig;
      SEL_OTHER: pin = other_sig;
      SEL_LOW:   pin = 1'b0;
      default:   pin = 1'b1;
    endcase
  end
endmodule

// File: rtl/cwt_core.sv
module cwt_core
  import cwt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCMP  = 4,
  parameter int LEN_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_sn,
  input  logic [FN_W-1:0]            cfg_mode,
  input  logic [NCMP-1:0][CNT_W-1:0] cfg_cmp,
  input  logic [LEN_W-1:0]           cfg_len,
  input  logic                       cfg_ie,
  input  logic                       restart,
  input  logic                       step,
  input  logic                       trig,
  output logic [CNT_W-1:0]           cnt_o,
  output logic                       lvl_o,
  output logic                       irq_o
);
  localparam int PAT_W = NCMP * CNT_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             lvl;
    logic             act;
    logic             ph;
    logic             fired;
  } st_t;

  st_t            st_q, st_d;
  logic           irq_q, ev;
  fn_e            mode;
  logic [CNT_W:0] nxt;
  logic [CNT_W-1:0] a_sel, t_sel, a_eff, t_eff, len_ext;
  logic [PAT_W-1:0] pat_vec;
  logic           pat_bit;

  assign mode    = fn_e'(cfg_mode);
  assign nxt     = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign a_sel   = st_q.ph ? cfg_cmp[2] : cfg_cmp[0];
  assign t_sel   = st_q.ph ? cfg_cmp[3] : cfg_cmp[1];
  assign a_eff   = (a_sel == '0) ? ONE : a_sel;
  assign t_eff   = (t_sel == '0) ? ONE : t_sel;
  assign len_ext = {{(CNT_W-LEN_W){1'b0}}, cfg_len};
  assign pat_vec = cfg_cmp;
  assign pat_bit = pat_vec[st_q.cnt[LEN_W-1:0]];

  always_comb begin
    st_d = st_q;
    ev   = 1'b0;
    if (restart) begin
      st_d.cnt   = '0;
      st_d.lvl   = 1'b0;
      st_d.act   = (mode != FN_PAT_ONCE);
      st_d.ph    = 1'b0;
      st_d.fired = 1'b0;
    end else begin
      unique case (mode)
        FN_ONCE: begin
          if (step && st_q.act) begin
            st_d.cnt = nxt[CNT_W-1:0];
            if (nxt >= {1'b0, a_eff}) begin
              st_d.lvl = 1'b1;
              st_d.act = 1'b0;
              ev       = 1'b1;
            end
          end
        end
        FN_REPEAT: begin
          if (step) begin
            if (nxt >= {1'b0, a_eff}) begin
              st_d.cnt = '0;
              st_d.lvl = 1'b1;
              ev       = 1'b1;
            end else begin
              st_d.cnt = nxt[CNT_W-1:0];
              st_d.lvl = 1'b0;
            end
          end
        end
        FN_PULSE_ONCE: begin
          if (step && st_q.act) begin
            if (nxt >= {1'b0, t_eff}) begin
              st_d.cnt = '0;
              st_d.lvl = 1'b0;
              st_d.act = 1'b0;
              ev       = 1'b1;
            end else begin
              st_d.cnt = nxt[CNT_W-1:0];
              if (nxt >= {1'b0, a_eff}) st_d.lvl = 1'b1;
            end
          end
        end
        FN_PULSE_REP, FN_ALT: begin
          if (step) begin
            if (nxt >= {1'b0, t_eff}) begin
              st_d.cnt = '0;
              st_d.lvl = 1'b0;
              st_d.ph  = (mode == FN_ALT) ? ~st_q.ph : st_q.ph;
              ev       = 1'b1;
            end else begin
              st_d.cnt = nxt[CNT_W-1:0];
              if (nxt >= {1'b0, a_eff}) st_d.lvl = 1'b1;
            end
          end
        end
        FN_PAT_ONCE: begin
          if (trig && !st_q.act) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
          end else if (step && st_q.act) begin
            if (st_q.cnt > len_ext) begin
              st_d.lvl = 1'b0;
              st_d.act = 1'b0;
              st_d.cnt = '0;
              ev       = 1'b1;
            end else begin
              st_d.lvl = pat_bit;
              st_d.cnt = nxt[CNT_W-1:0];
            end
          end
        end
        FN_PAT_REP: begin
          if (trig) begin
            st_d.act = 1'b0;
            st_d.lvl = 1'b0;
          end else if (step && st_q.act) begin
            st_d.lvl = pat_bit;
            if (st_q.cnt >= len_ext) begin
              st_d.cnt = '0;
              ev       = 1'b1;
            end else begin
              st_d.cnt = nxt[CNT_W-1:0];
            end
          end
        end
        default: begin // FN_FREE
          if (step) begin
            st_d.cnt = nxt[CNT_W-1:0];
            if (!st_q.fired && (nxt >= {1'b0, a_eff})) begin
              st_d.fired = 1'b1;
              st_d.lvl   = 1'b1;
              ev         = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q.cnt   <= '0;
      st_q.lvl   <= 1'b0;
      st_q.act   <= 1'b1;
      st_q.ph    <= 1'b0;
      st_q.fired <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= ev & cfg_ie;
    end
  end

  assign cnt_o = st_q.cnt;
  assign lvl_o = st_q.lvl;
  assign irq_o = irq_q;
endmodule

// File: rtl/cmp_wave_timer.sv
module cmp_wave_timer
  import cwt_pkg::*;
#(
  parameter  int CNT_W = 16,
  parameter  int NCMP  = 4,
  localparam int LEN_W = $clog2(NCMP * CNT_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [FN_W-1:0]            cfg_mode,
  input  logic [NCMP-1:0][CNT_W-1:0] cfg_cmp,
  input  logic [LEN_W-1:0]           cfg_len,
  input  logic                       cfg_pol,
  input  logic                       cfg_en,
  input  logic                       cfg_clr,
  input  logic                       cfg_ie,
  input  logic [SEL_W-1:0]           cfg_osel,
  input  logic [SEL_W-1:0]           cfg_osel2,
  input  logic                       glb_en,
  input  logic                       tick,
  input  logic                       trig,
  output logic                       out_pri,
  output logic                       out_sec,
  output logic                       irq
);
  localparam int NPIN = 2;

  logic             rst_sn, restart, step;
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q, prim_sig;
  logic [NPIN-1:0]  own_v, other_v, pin_v;
  logic [NPIN-1:0][SEL_W-1:0] sel_v;

  cwt_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_mode(cfg_mode),
    .cfg_clr (cfg_clr),
    .cfg_en  (cfg_en),
    .glb_en  (glb_en),
    .tick    (tick),
    .rst_sn  (rst_sn),
    .restart (restart),
    .step    (step)
  );

  cwt_core #(.CNT_W(CNT_W), .NCMP(NCMP), .LEN_W(LEN_W)) u_core (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .cfg_mode(cfg_mode),
    .cfg_cmp (cfg_cmp),
    .cfg_len (cfg_len),
    .cfg_ie  (cfg_ie),
    .restart (restart),
    .step    (step),
    .trig    (trig),
    .cnt_o   (cnt_q),
    .lvl_o   (lvl_q),
    .irq_o   (irq)
  );

  assign prim_sig   = lvl_q ^ cfg_pol;
  assign own_v[0]   = prim_sig;
  assign own_v[1]   = ~prim_sig;
  assign other_v[0] = ~prim_sig;
  assign other_v[1] = prim_sig;
  assign sel_v[0]   = cfg_osel;
  assign sel_v[1]   = cfg_osel2;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    cwt_outsel u_sel (
      .own_sig  (own_v[g]),
      .other_sig(other_v[g]),
      .sel      (sel_v[g]),
      .pin      (pin_v[g])
    );
  end

  assign out_pri = pin_v[0];
  assign out_sec = pin_v[1];
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker
  import cwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sn,
  input logic [FN_W-1:0]  cfg_mode,
  input logic             cfg_clr,
  input logic             cfg_en,
  input logic             glb_en,
  input logic             cfg_ie,
  input logic [SEL_W-1:0] cfg_osel,
  input logic [SEL_W-1:0] cfg_osel2,
  input logic             trig,
  input logic             restart,
  input logic [CNT_W-1:0] cnt,
  input logic             lvl,
  input logic             irq,
  input logic             out_pri,
  input logic             out_sec
);
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    cfg_clr |=> (cnt == '0));

  a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_sn)
    (!(cfg_en && glb_en) && !restart && !trig) |=> $stable(cnt));

  a_r4_once_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_mode == FN_ONCE && lvl && !restart) |=> lvl);

  a_r11_free_single: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_mode == FN_FREE && lvl && !restart) |=> lvl);

  a_r12_complement: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_osel == SEL_OWN && cfg_osel2 == SEL_OWN) |-> (out_pri != out_sec));

  a_r12_forced: assert property (@(posedge clk) disable iff (!rst_sn)
    cfg_osel[1] |-> (out_pri == cfg_osel[0]));

  a_r13_irq_gated: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> $past(cfg_ie));
endmodule

bind cmp_wave_timer cwt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .cfg_mode (cfg_mode),
  .cfg_clr  (cfg_clr),
  .cfg_en   (cfg_en),
  .glb_en   (glb_en),
  .cfg_ie   (cfg_ie),
  .cfg_osel (cfg_osel),
  .cfg_osel2(cfg_osel2),
  .trig     (trig),
  .restart  (restart),
  .cnt      (cnt_q),
  .lvl      (lvl_q),
  .irq      (irq),
  .out_pri  (out_pri),
  .out_sec  (out_sec)
);

// File: tb/cmp_wave_timer_bench.sv
module cmp_wave_timer_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] mode;
  logic [3:0][15:0] cmp;
  logic [5:0] len;
  logic pol, en, clr, ie, glb, tick, trig;
  logic [1:0] osel, osel2;
  wire  out_pri, out_sec, irq;

  int n_chk = 0, n_err = 0, cyc_n = 0;
  bit chk_on = 0, done_f = 0;
  string cur_req = "R1";
  int tick_mode = 0;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  cmp_wave_timer u_cmp_wave_timer (
    .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_cmp(cmp), .cfg_len(len),
    .cfg_pol(pol), .cfg_en(en), .cfg_clr(clr), .cfg_ie(ie), .cfg_osel(osel),
    .cfg_osel2(osel2), .glb_en(glb), .tick(tick), .trig(trig),
    .out_pri(out_pri), .out_sec(out_sec), .irq(irq)
  );

  // behavioural reference
  int  m_cnt, m_mq;
  bit  m_lvl, m_act, m_ph, m_fired, m_irq, m_rs1, m_rs2;

  function automatic bit pbit(int i);
    return cmp[(i >> 4) & 3][i & 15];
  endfunction

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic m_park();
    m_cnt = 0; m_lvl = 0; m_act = 1; m_ph = 0; m_fired = 0; m_irq = 0; m_mq = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_park(); m_rs1 = 0; m_rs2 = 0;
    end else begin
      if (!m_rs2) m_park();
      else begin
        bit ev, st;
        int dly, term, md;
        md  = int'(mode);
        ev  = 0;
        st  = tick && en && glb;
        dly  = eff(m_ph ? int'(cmp[2]) : int'(cmp[0]));
        term = eff(m_ph ? int'(cmp[3]) : int'(cmp[1]));
        if (clr || md != m_mq) begin
          m_cnt = 0; m_lvl = 0; m_act = (md != 4); m_ph = 0; m_fired = 0;
        end else if (md == 0) begin
          if (st && m_act) begin
            m_cnt++;
            if (m_cnt >= dly) begin m_lvl = 1; m_act = 0; ev = 1; end
          end
        end else if (md == 1) begin
          if (st) begin
            if (m_cnt + 1 >= dly) begin m_cnt = 0; m_lvl = 1; ev = 1; end
            else begin m_cnt++; m_lvl = 0; end
          end
        end else if (md == 2) begin
          if (st && m_act) begin
            if (m_cnt + 1 >= term) begin m_cnt = 0; m_lvl = 0; m_act = 0; ev = 1; end
            else begin m_cnt++; if (m_cnt >= dly) m_lvl = 1; end
          end
        end else if (md == 3 || md == 7) begin
          if (st) begin
            if (m_cnt + 1 >= term) begin
              m_cnt = 0; m_lvl = 0; ev = 1;
              if (md == 7) m_ph = !m_ph;
            end else begin m_cnt++; if (m_cnt >= dly) m_lvl = 1; end
          end
        end else if (md == 4) begin
          if (trig && !m_act) begin m_act = 1; m_cnt = 0; end
          else if (st && m_act) begin
            if (m_cnt > int'(len)) begin m_lvl = 0; m_act = 0; m_cnt = 0; ev = 1; end
            else begin m_lvl = pbit(m_cnt); m_cnt++; end
          end
        end else if (md == 5) begin
          if (trig) begin m_act = 0; m_lvl = 0; end
          else if (st && m_act) begin
            m_lvl = pbit(m_cnt);
            if (m_cnt >= int'(len)) begin m_cnt = 0; ev = 1; end
            else m_cnt++;
          end
        end else begin
          if (st) begin
            if (!m_fired && m_cnt + 1 >= dly) begin m_fired = 1; m_lvl = 1; ev = 1; end
            m_cnt = (m_cnt + 1) & 16'hFFFF;
          end
        end
        m_irq = ev && ie;
        m_mq  = md;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  function automatic bit pick(logic [1:0] s, bit own, bit other);
    case (s)
      2'd0: return own;
      2'd1: return other;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      bit ep;
      logic [2:0] got, expv;
      ep   = m_lvl ^ pol;
      expv = {pick(osel, ep, !ep), pick(osel2, !ep, ep), m_irq};
      got  = {out_pri, out_sec, irq};
      n_chk++;
      if (got !== expv) begin
        n_err++;
        $display("FAIL %s: {pri,sec,irq}=%b expected %b at cycle %0d", cur_req, got, expv, cyc_n);
      end
    end
  end

  task automatic dcheck(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc_n);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      cyc_n++;
      lf   = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tick = (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? lf[0] : 1'b0;
      trig = 1'b0;
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    cyc(1);
  endtask

  initial begin
    rst_n = 0; mode = 0; cmp = '0; len = 0; pol = 0; en = 0; clr = 0; ie = 0;
    glb = 0; tick = 0; trig = 0; osel = 0; osel2 = 0;
    cyc(5);
    rst_n = 1;
    chk_on = 1;
    cyc(4);
    // R1 reset state
    dcheck("R1", out_pri, 1'b0);
    dcheck("R1", out_sec, 1'b1);
    dcheck("R1", irq, 1'b0);

    // R2 enables gate counting, clear parks the engine
    cur_req = "R2";
    cmp[0] = 16'd3; en = 1; ie = 1; tick_mode = 1;
    cyc(12);
    dcheck("R2", out_pri, 1'b0);
    glb = 1;
    cyc(6);
    dcheck("R2", out_pri, 1'b1);
    clr = 1;
    cyc(3);
    dcheck("R2", out_pri, 1'b0);
    clr = 0;

    cur_req = "R4";
    cmp[0] = 16'd7; tick_mode = 2;
    cyc(40);

    cur_req = "R5";
    mode = 3'd1; cmp[0] = 16'd4; tick_mode = 1;
    cyc(30);
    cmp[0] = 16'd0;
    cyc(8);

    cur_req = "R6";
    mode = 3'd2; cmp[0] = 16'd2; cmp[1] = 16'd6; tick_mode = 2;
    cyc(40);

    cur_req = "R7";
    mode = 3'd3; cmp[0] = 16'd3; cmp[1] = 16'd5; tick_mode = 1;
    cyc(30);
    tick_mode = 2;
    cyc(30);
    cmp[0] = 16'd0; cmp[1] = 16'd0;
    cyc(10);
    cmp[0] = 16'd3; cmp[1] = 16'd5;

    cur_req = "R12";
    pol = 1; cyc(10);
    for (int s = 1; s < 4; s++) begin osel = 2'(s); cyc(6); end
    osel = 0;
    for (int s = 1; s < 4; s++) begin osel2 = 2'(s); cyc(6); end
    osel2 = 0; pol = 0;
    cyc(4);

    cur_req = "R3";
    mode = 3'd1; cmp[0] = 16'd3;
    cyc(1);
    dcheck("R3", out_pri, 1'b0);
    cyc(12);

    cur_req = "R8";
    mode = 3'd7; cmp[0] = 16'd2; cmp[1] = 16'd5; cmp[2] = 16'd1; cmp[3] = 16'd3;
    tick_mode = 2;
    cyc(60);

    cur_req = "R9";
    mode = 3'd4; cmp[0] = 16'hA5C3; cmp[1] = 16'h0F0F; cmp[2] = 16'h1234; cmp[3] = 16'h8001;
    len = 6'd20; tick_mode = 1;
    cyc(5);
    pulse_trig();
    cyc(30);
    tick_mode = 2;
    pulse_trig();
    cyc(60);
    len = 6'd63; tick_mode = 1;
    pulse_trig();
    cyc(70);

    cur_req = "R10";
    mode = 3'd5; cmp[0] = 16'h002D; len = 6'd5;
    cyc(30);
    pulse_trig();
    cyc(10);
    dcheck("R10", out_pri, 1'b0);

    cur_req = "R13";
    ie = 0; mode = 3'd1; cmp[0] = 16'd2;
    cyc(20);
    ie = 1;
    cyc(10);

    cur_req = "R11";
    mode = 3'd6; cmp[0] = 16'd4;
    cyc(65560);
    dcheck("R11", out_pri, 1'b1);

    done_f = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_f) begin
      n_err++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule